// File: doc/BRIEF.md
# Single-Word Handshake Buffer

This block sits between a producer and a consumer that each speak a four-phase request/acknowledge protocol. It stores exactly one data word. A producer offers a word by driving `in_data` and raising `in_req`. If the store is empty, the block captures the word and raises `in_ack`. It keeps `in_ack` high until the producer withdraws its request. Once the store holds a word, the block presents it on `out_data` and raises `out_req`. It holds that request until the consumer acknowledges. The consumer then finishes by dropping `out_ack`.

The block has four parts: an input-side controller, an output-side controller, an occupancy flag and a data register. The occupancy flag makes the two handshakes take turns. A new input acknowledge is possible only after the consumer has taken the previous word, and a new output request only follows a fresh capture. As a result, no word is lost and no word is delivered twice. All inputs are synchronous to `clk`. The reset is synchronous and active high.

Top module: `hs_word_buffer`

## Requirements
- R1: While `rst` is high and on the cycle after it, `in_ack` and `out_req` are low. After reset the store is empty, so a new `in_req` is acknowledged even if a word was held before the reset.
- R2: When `in_req` is sampled high and the store is empty, `in_ack` is high from the next cycle, and the word on `in_data` at that edge is the one captured.
- R3: While the store holds a word, `in_req` is never acknowledged: `in_ack` stays low.
- R4: `in_ack` stays high as long as `in_req` stays high. It falls on the cycle after `in_req` is sampled low.
- R5: `out_req` rises one cycle after a capture, unless the previous output handshake is still completing. While `out_req` is high, `out_data` shows the captured word.
- R6: `out_req` stays high until `out_ack` is sampled high. It falls on the following cycle, and `out_data` does not change while the request waits.
- R7: The store becomes empty on the edge where `out_ack` is sampled high with `out_req` high, so a waiting producer is acknowledged on the next cycle. `out_req` is not raised again while `out_ack` is still high.
- R8: The data register loads only on the capture edge. Changes on `in_data` at any other time have no effect on `out_data`.
- R9: Rising edges of `in_ack` and `out_ack` strictly alternate, starting with `in_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Producer request |
| in_data | input | DATA_W | Producer data word |
| in_ack | output | 1 | Acknowledge to producer |
| out_req | output | 1 | Request to consumer |
| out_data | output | DATA_W | Stored word toward consumer |
| out_ack | input | 1 | Consumer acknowledge |

## Verification
The bench raises `in_req` while the store is full. A design that ignored the occupancy flag would acknowledge that request and overwrite the pending word. It changes `in_data` while `in_ack` is high and while the store is full; a register that loaded on any cycle with `in_req` high would corrupt `out_data`. It holds `out_ack` high across the point where a new word is captured. A design that let the output side start at once would raise `out_req` early and break the alternation of acknowledges. Finally, it applies a reset in the middle of a transfer. A design that kept the occupancy flag would then refuse the next word.

// File: rtl/hs_buf_pkg.sv
package hs_buf_pkg;
   typedef enum logic {
      IN_IDLE,
      IN_ACKED
   } in_state_e;

   typedef enum logic [1:0] {
      OUT_IDLE,
      OUT_OFFER,
      OUT_DRAIN
   } out_state_e;
endpackage

// File: rtl/hs_in_ctrl.sv
module hs_in_ctrl
   import hs_buf_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic in_req,
   input  logic full,
   output logic in_ack,
   output logic capture
);
   in_state_e st_q, st_d;

   always_comb begin
      st_d    = st_q;
      capture = 1'b0;
      case (st_q)
         IN_IDLE: if (in_req && !full) begin
            st_d    = IN_ACKED;
            capture = 1'b1;
         end
         IN_ACKED: if (!in_req) st_d = IN_IDLE;
         default: st_d = IN_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= IN_IDLE;
      else     st_q <= st_d;
   end

   assign in_ack = (st_q == IN_ACKED);

   assert_ack_blocked_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(in_ack) |-> $past(!full));
   assert_ack_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (in_ack && in_req) |=> in_ack);
   assert_ack_drop_R4: assert property (@(posedge clk) disable iff (rst)
      (in_ack && !in_req) |=> !in_ack);
endmodule

// File: rtl/hs_out_ctrl.sv
module hs_out_ctrl
   import hs_buf_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic full,
   input  logic out_ack,
   output logic out_req,
   output logic taken
);
   out_state_e st_q, st_d;

   always_comb begin
      st_d  = st_q;
      taken = 1'b0;
      case (st_q)
         OUT_IDLE:  if (full) st_d = OUT_OFFER;
         OUT_OFFER: if (out_ack) begin
            st_d  = OUT_DRAIN;
            taken = 1'b1;
         end
         OUT_DRAIN: if (!out_ack) st_d = OUT_IDLE;
         default:   st_d = OUT_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= OUT_IDLE;
      else     st_q <= st_d;
   end

   assign out_req = (st_q == OUT_OFFER);

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (out_req && !out_ack) |=> out_req);
   assert_req_drop_R6: assert property (@(posedge clk) disable iff (rst)
      (out_req && out_ack) |=> !out_req);
   assert_no_rereq_R7: assert property (@(posedge clk) disable iff (rst)
      (!out_req && out_ack) |=> !out_req);
endmodule

// File: rtl/hs_occ_flag.sv
module hs_occ_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic full
);
   always_ff @(posedge clk) begin
      if (rst)        full <= 1'b0;
      else if (set_i) full <= 1'b1;
      else if (clr_i) full <= 1'b0;
   end

   assert_set_R2: assert property (@(posedge clk) disable iff (rst)
      set_i |=> full);
   assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> !full);
   assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({set_i, clr_i}));
endmodule

// File: rtl/hs_data_reg.sv
module hs_data_reg #(
   parameter int DATA_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   if (DATA_W < 1) begin : g_bad_width
      $error("hs_data_reg: DATA_W must be at least 1");
   end

   if (CLEAR_ON_RESET) begin : g_rst
      always_ff @(posedge clk) begin
         if (rst)       q <= '0;
         else if (load) q <= d;
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (load) q <= d;
      end
   end

   assert_load_only_R8: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));
endmodule

// File: rtl/hs_word_buffer.sv
module hs_word_buffer #(
   parameter int DATA_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_req,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ack,
   output logic              out_req,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ack
);
   if (DATA_W < 1) begin : g_bad_width
      $error("hs_word_buffer: DATA_W must be at least 1");
   end

   logic full, capture, taken;

   hs_in_ctrl u_in (
      .clk(clk), .rst(rst), .in_req(in_req), .full(full),
      .in_ack(in_ack), .capture(capture)
   );

   hs_out_ctrl u_out (
      .clk(clk), .rst(rst), .full(full), .out_ack(out_ack),
      .out_req(out_req), .taken(taken)
   );

   hs_occ_flag u_occ (
      .clk(clk), .rst(rst), .set_i(capture), .clr_i(taken), .full(full)
   );

   hs_data_reg #(.DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_data (
      .clk(clk), .rst(rst), .load(capture), .d(in_data), .q(out_data)
   );

   // Alternation tracking: which acknowledge rose last.
   logic in_ack_q, out_ack_q, last_was_in;
   logic in_rise, out_rise;
   assign in_rise  = in_ack && !in_ack_q;
   assign out_rise = out_ack && !out_ack_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_ack_q    <= 1'b0;
         out_ack_q   <= 1'b0;
         last_was_in <= 1'b0;
      end else begin
         in_ack_q  <= in_ack;
         out_ack_q <= out_ack;
         if (in_rise)       last_was_in <= 1'b1;
         else if (out_rise) last_was_in <= 1'b0;
      end
   end

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (!in_ack && !out_req));
   assert_data_stable_R6: assert property (@(posedge clk) disable iff (rst)
      (out_req && !out_ack) |=> $stable(out_data));
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
      in_rise |-> !last_was_in);
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
      out_rise |-> last_was_in);
endmodule

// File: tb/test_hs_word_buffer.sv
module test_hs_word_buffer;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_req = 1'b0;
   logic [W-1:0] in_data = '0;
   logic out_ack = 1'b0;
   logic in_ack, out_req;
   logic [W-1:0] out_data;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   hs_word_buffer #(.DATA_W(W)) i_hs_word_buffer (
      .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data),
      .in_ack(in_ack), .out_req(out_req), .out_data(out_data),
      .out_ack(out_ack)
   );

   typedef struct packed {
      logic         req;
      logic [W-1:0] d;
      logic         oack;
      logic         e_iack;
      logic         e_oreq;
      logic         chk_d;
      logic [W-1:0] e_d;
      logic [3:0]   rq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         4'd1}, // R1 idle
      '{1'b1, 32'hA5A5_0001, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         4'd2}, // R2 capture
      '{1'b1, 32'hFFFF_0000, 1'b0, 1'b1, 1'b1, 1'b1, 32'hA5A5_0001, 4'd8}, // R8, R5
      '{1'b0, 32'h1111_1111, 1'b0, 1'b0, 1'b1, 1'b1, 32'hA5A5_0001, 4'd4}, // R4 drop
      '{1'b1, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b1, 32'hA5A5_0001, 4'd3}, // R3 full
      '{1'b1, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b1, 32'hA5A5_0001, 4'd6}, // R6 hold
      '{1'b1, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'd6}, // R6 drop
      '{1'b1, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,         4'd7}, // R7 refill
      '{1'b1, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         4'd7}, // R7 no early req
      '{1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 32'h1234_5678, 4'd5}, // R5 present
      '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'd6}, // R6
      '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'd7}, // R7
      '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         4'd7}, // R7 empty
      '{1'b1, 32'h0BAD_F00D, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         4'd2}, // R2
      '{1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 32'h0BAD_F00D, 4'd5}  // R5
   };

   task automatic check1(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R9 alternation monitor on acknowledge rising edges
   logic mon_en = 1'b0;
   logic pend = 1'b0;
   logic ia_q = 1'b0, oa_q = 1'b0;
   int viol = 0;
   always @(negedge clk) begin
      if (mon_en) begin
         if (in_ack && !ia_q) begin
            if (pend) viol++;
            pend = 1'b1;
         end
         if (out_ack && !oa_q) begin
            if (!pend) viol++;
            pend = 1'b0;
         end
      end
      ia_q = in_ack;
      oa_q = out_ack;
   end

   initial begin
      #(8 * 200000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check1("R1 in_ack in reset", {31'b0, in_ack}, '0);
      check1("R1 out_req in reset", {31'b0, out_req}, '0);
      rst = 1'b0;
      mon_en = 1'b1;

      for (int i = 0; i < NV; i++) begin
         in_req  = VEC[i].req;
         in_data = VEC[i].d;
         out_ack = VEC[i].oack;
         @(posedge clk);
         @(negedge clk);
         check1($sformatf("R%0d row %0d in_ack", VEC[i].rq, i),
                {31'b0, in_ack}, {31'b0, VEC[i].e_iack});
         check1($sformatf("R%0d row %0d out_req", VEC[i].rq, i),
                {31'b0, out_req}, {31'b0, VEC[i].e_oreq});
         if (VEC[i].chk_d)
            check1($sformatf("R%0d row %0d out_data", VEC[i].rq, i),
                   out_data, VEC[i].e_d);
      end

      mon_en = 1'b0;
      check1("R9 acknowledge alternation violations", viol, 0);

      // R1: reset in the middle of a transfer (out_req is high, store full)
      rst = 1'b1;
      in_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check1("R1 out_req after mid reset", {31'b0, out_req}, '0);
      check1("R1 in_ack after mid reset", {31'b0, in_ack}, '0);
      rst = 1'b0;
      in_req = 1'b1;
      in_data = 32'hCAFE_0042;
      @(posedge clk);
      @(negedge clk);
      check1("R1 store empty after reset, in_ack", {31'b0, in_ack}, 32'd1);
      in_req = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check1("R5 out_req after reset capture", {31'b0, out_req}, 32'd1);
      check1("R5 out_data after reset capture", out_data, 32'hCAFE_0042);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule